// File: doc/BRIEF.md
# Differential Phase Readout Decimator

This block sits behind a pair of phase-tracking channels that follow the same beat note. Each cycle it may accept one sample: both channels' phase accumulators and both channels' frequency words. The two accumulators are subtracted at full rate, modulo their width. A sawtooth that wraps every few cycles never reaches a filter, and what remains is the slowly moving phase difference between the channels.

The difference and each channel's frequency word then pass through their own cascaded integrator-comb decimator. All three decimators share one decimation schedule. The ratio is chosen at run time as a power of two. Each filter removes its own DC gain with an arithmetic shift of the order times log2 of the ratio. Its full-precision result is then cut down to a fixed readout width by dropping low-order bits. One valid pulse marks each decimated output set.

Top module: `phase_readout_decim`

## Requirements
- R1: While reset is held and in the cycle after it is released, `out_vld` is 0 and `dphase`, `freq_a` and `freq_b` are all zero.
- R2: The channel difference is `acc_a - acc_b` modulo 2^PA_W, read as a signed value. A constant offset gives the same readout whether or not one accumulator has wrapped past zero and the other has not. Negative offsets and the most negative offset are included.
- R3: With a constant accumulator offset `d` and the filter settled, `dphase` equals `d >>> (PA_W - DPH_W)`. This is the top DPH_W bits of the signed difference.
- R4: With a constant frequency word `f` on a channel and the filter settled, that channel's output equals `f >> (PI_W - FRQ_W)`. This is the top FRQ_W bits of the word.
- R5: With `dec_log2 = k` (valid range 1..MAX_LOG2), one output set is produced per 2^k accepted samples. The n-th `out_vld` pulse follows exactly n·2^k accepted samples after reset.
- R6: `out_vld` is high for single cycles only. `dphase`, `freq_a` and `freq_b` change only in a cycle where `out_vld` is high.
- R7: A cycle with `smp_vld` low changes no filter state and does not advance the decimation count. Samples that arrive with gaps produce the same outputs, at the same sample count, as contiguous ones.
- R8: The settled readout for a given input does not depend on the selected ratio. The filter gain 2^(ORDER·k) is removed exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | A new sample is present on the four data inputs |
| dec_log2 | input | SH_W | log2 of the decimation ratio, 1..MAX_LOG2 |
| acc_a | input | PA_W | Channel A phase accumulator |
| acc_b | input | PA_W | Channel B phase accumulator |
| inc_a | input | PI_W | Channel A frequency word (signed) |
| inc_b | input | PI_W | Channel B frequency word (signed) |
| out_vld | output | 1 | One-cycle pulse per decimated output set |
| dphase | output | DPH_W | Decimated, truncated phase difference A minus B |
| freq_a | output | FRQ_W | Decimated, truncated channel A frequency word |
| freq_b | output | FRQ_W | Decimated, truncated channel B frequency word |

## Verification
Two events can fall on the same sample. One is an accumulator wrap in one channel while the other channel has not yet wrapped. The other is the decimation instant, when the comb stage latches the integrator sum. The bench drives two ramps that start just below the wrap point and advance by a step that does not divide 2^PA_W. Wraps of A alone, of B alone, and decimation ticks therefore land on every relative alignment across many outputs. The readout is judged against the offset shifted down to DPH_W bits at every settled pulse, and it must not change between pulses. Gapped sample streams repeat the same alignments with idle cycles in between.

// File: rtl/readout_pkg.sv
package readout_pkg;

  // Full-precision width of a CIC built for ratios up to 2^max_log2
  function automatic int cic_width(int in_w, int order, int max_log2);
    return in_w + order * max_log2;
  endfunction

  // Shift that removes the CIC DC gain R^order for R = 2^log2r
  function automatic int gain_shift(int order, int log2r);
    return order * log2r;
  endfunction

endpackage

// File: rtl/dec_strobe.sv
module dec_strobe #(
  parameter int MAX_LOG2 = 6,
  parameter int SH_W     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            smp_vld,
  input  logic [SH_W-1:0] dec_log2,
  output logic            dec_tick
);
  localparam int CW = MAX_LOG2 + 1;
  localparam logic [CW-1:0] ONE = 1;

  logic [CW-1:0] limit;
  logic [CW-1:0] cnt;
  logic          at_end;

  assign limit    = (ONE << dec_log2) - ONE;
  assign at_end   = (cnt >= limit);
  assign dec_tick = smp_vld && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (smp_vld) cnt <= at_end ? '0 : cnt + ONE;
  end

  // R7: idle cycles never move the sample count
  a_r7_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(cnt));

endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import readout_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int OUT_W    = 8,
  parameter int ORDER    = 3,
  parameter int MAX_LOG2 = 6,
  parameter int SH_W     = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic                    dec_tick,
  input  logic [SH_W-1:0]         dec_log2,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout,
  output logic                    dout_vld
);
  localparam int W    = cic_width(IN_W, ORDER, MAX_LOG2);
  localparam int DROP = IN_W - OUT_W;

  logic signed [W-1:0] din_ext;
  logic signed [W-1:0] integ    [ORDER];
  logic signed [W-1:0] comb_dly [ORDER];
  logic signed [W-1:0] comb_in  [ORDER+1];
  logic signed [OUT_W-1:0] rd_val;

  assign din_ext = {{(W-IN_W){din[IN_W-1]}}, din};

  for (genvar k = 0; k < ORDER; k++) begin : g_integ
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n)      integ[k] <= '0;
        else if (in_vld) integ[k] <= integ[k] + din_ext;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n)      integ[k] <= '0;
        else if (in_vld) integ[k] <= integ[k] + integ[k-1];
      end
    end
  end

  assign comb_in[0] = integ[ORDER-1];
  for (genvar k = 0; k < ORDER; k++) begin : g_comb
    assign comb_in[k+1] = comb_in[k] - comb_dly[k];
    always_ff @(posedge clk) begin
      if (!rst_n)        comb_dly[k] <= '0;
      else if (dec_tick) comb_dly[k] <= comb_in[k];
    end
  end

  // remove the DC gain, then drop the insignificant low bits
  assign rd_val = OUT_W'(comb_in[ORDER] >>> (gain_shift(ORDER, int'(dec_log2)) + DROP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= dec_tick;
      if (dec_tick) dout <= rd_val;
    end
  end

  // R7: no sample, no integrator movement
  a_r7_integ_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(integ[ORDER-1]));
  // R5: decimation instants coincide with accepted samples
  a_r5_tick_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    dec_tick |-> in_vld);
  // R6: readout holds between pulses
  a_r6_dout_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> $stable(dout));

endmodule

// File: rtl/phase_readout_decim.sv
module phase_readout_decim #(
  parameter int PA_W     = 16,
  parameter int PI_W     = 40,
  parameter int DPH_W    = 8,
  parameter int FRQ_W    = 38,
  parameter int ORDER    = 3,
  parameter int MAX_LOG2 = 6,
  parameter int SH_W     = $clog2(MAX_LOG2 + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [SH_W-1:0]  dec_log2,
  input  logic [PA_W-1:0]  acc_a,
  input  logic [PA_W-1:0]  acc_b,
  input  logic [PI_W-1:0]  inc_a,
  input  logic [PI_W-1:0]  inc_b,
  output logic             out_vld,
  output logic [DPH_W-1:0] dphase,
  output logic [FRQ_W-1:0] freq_a,
  output logic [FRQ_W-1:0] freq_b
);
  localparam int NCH = 2;

  logic                    dec_tick;
  logic signed [PA_W-1:0]  dph_diff;
  logic signed [DPH_W-1:0] dph_q;
  logic signed [PI_W-1:0]  inc_ch [NCH];
  logic signed [FRQ_W-1:0] frq_q  [NCH];
  logic [NCH-1:0]          frq_vld;

  // modulo-2^PA_W difference, read as signed: cancels the common ramp
  assign dph_diff = acc_a - acc_b;
  assign inc_ch[0] = inc_a;
  assign inc_ch[1] = inc_b;

  dec_strobe #(.MAX_LOG2(MAX_LOG2), .SH_W(SH_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
    .dec_log2(dec_log2), .dec_tick(dec_tick)
  );

  cic_decim #(.IN_W(PA_W), .OUT_W(DPH_W), .ORDER(ORDER),
              .MAX_LOG2(MAX_LOG2), .SH_W(SH_W)) u_cic_dph (
    .clk(clk), .rst_n(rst_n), .in_vld(smp_vld), .dec_tick(dec_tick),
    .dec_log2(dec_log2), .din(dph_diff), .dout(dph_q), .dout_vld(out_vld)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_frq
    cic_decim #(.IN_W(PI_W), .OUT_W(FRQ_W), .ORDER(ORDER),
                .MAX_LOG2(MAX_LOG2), .SH_W(SH_W)) u_cic_frq (
      .clk(clk), .rst_n(rst_n), .in_vld(smp_vld), .dec_tick(dec_tick),
      .dec_log2(dec_log2), .din(inc_ch[c]), .dout(frq_q[c]),
      .dout_vld(frq_vld[c])
    );
  end

  assign dphase = dph_q;
  assign freq_a = frq_q[0];
  assign freq_b = frq_q[1];

  // R6: a pulse never lasts two cycles
  a_r6_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);
  // R5: all three decimators emit on the same cycle
  a_r5_vld_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    frq_vld == {NCH{out_vld}});

endmodule

// File: tb/phase_readout_decim_tb.sv
module phase_readout_decim_tb;
  localparam int PA_W = 16, PI_W = 40, DPH_W = 8, FRQ_W = 38;
  localparam int NOUT = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             smp_vld = 1'b0;
  logic [2:0]       dec_log2 = 3'd1;
  logic [PA_W-1:0]  acc_a = '0, acc_b = '0;
  logic [PI_W-1:0]  inc_a = '0, inc_b = '0;
  logic             out_vld;
  logic [DPH_W-1:0] dphase;
  logic [FRQ_W-1:0] freq_a, freq_b;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phase_readout_decim u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .dec_log2(dec_log2),
    .acc_a(acc_a), .acc_b(acc_b), .inc_a(inc_a), .inc_b(inc_b),
    .out_vld(out_vld), .dphase(dphase), .freq_a(freq_a), .freq_b(freq_b)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    check(out_vld == 1'b0, "R1", "out_vld", longint'(out_vld), 0);
    check(dphase == '0, "R1", "dphase", longint'(dphase), 0);
    check(freq_a == '0, "R1", "freq_a", longint'(freq_a), 0);
    check(freq_b == '0, "R1", "freq_b", longint'(freq_b), 0);
  endtask

  // One scenario: ramps with constant offset, constant frequency words
  task automatic t_case(string tag, int k, logic [PA_W-1:0] off,
                        logic [PI_W-1:0] ia, logic [PI_W-1:0] ib, bit gap);
    logic [PA_W-1:0]  base = 16'hFFF0;
    logic [DPH_W-1:0] exp_d = off[PA_W-1 -: DPH_W];
    logic [FRQ_W-1:0] exp_a = ia[PI_W-1 -: FRQ_W];
    logic [FRQ_W-1:0] exp_b = ib[PI_W-1 -: FRQ_W];
    logic [DPH_W-1:0] last_d = '0;
    logic [FRQ_W-1:0] last_a = '0, last_b = '0;
    int  nsmp = 0, nout = 0, steps = 0;
    bit  prev_vld = 1'b0, pulse_ok = 1'b1, hold_ok = 1'b1, wrap_ok = 1'b1;
    dec_log2 = 3'(k);
    inc_a = ia; inc_b = ib;
    do_reset();
    while (nout < NOUT && steps < 5000) begin
      // observe what the last edge produced
      if (out_vld) begin
        nout++;
        if (prev_vld) pulse_ok = 1'b0;
        if (nout >= 5 && dphase != exp_d) wrap_ok = 1'b0;
        if (nout == NOUT)
          check(nsmp == NOUT * (1 << k), "R5", {tag, " samples per output"},
                longint'(nsmp), longint'(NOUT * (1 << k)));
        last_d = dphase; last_a = freq_a; last_b = freq_b;
      end else if (dphase != last_d || freq_a != last_a || freq_b != last_b) begin
        hold_ok = 1'b0;
      end
      prev_vld = out_vld;
      // drive the next sample (idle every other cycle in gap mode)
      if (gap && steps[0]) begin
        smp_vld = 1'b0;
        acc_a = 16'h5A5A; acc_b = 16'h0F0F;
      end else begin
        smp_vld = 1'b1;
        acc_a = base; acc_b = base - off;
        base = base + 16'h1357;
        nsmp++;
      end
      steps++;
      @(negedge clk);
    end
    smp_vld = 1'b0;
    check(nout == NOUT, "R5", {tag, " output count"}, longint'(nout), NOUT);
    check(dphase == exp_d, "R3", {tag, " dphase"}, longint'(dphase), longint'(exp_d));
    check(wrap_ok, "R2", {tag, " dphase steady across wraps"}, longint'(wrap_ok), 1);
    check(freq_a == exp_a, "R4", {tag, " freq_a"}, longint'(freq_a), longint'(exp_a));
    check(freq_b == exp_b, "R4", {tag, " freq_b"}, longint'(freq_b), longint'(exp_b));
    check(pulse_ok, "R6", {tag, " single-cycle pulses"}, longint'(pulse_ok), 1);
    check(hold_ok, "R6", {tag, " outputs hold between pulses"}, longint'(hold_ok), 1);
  endtask

  initial begin : watchdog
    wait (cyc >= 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    // R3 R4 R5: basic positive offset, ratio 4
    t_case("r3_pos", 2, 16'h0500, 40'h12_3456_789C, 40'h12_3456_7000, 1'b0);
    // R8: same input at ratio 2 and ratio 64 must read the same
    t_case("r8_ratio2", 1, 16'h0500, 40'h12_3456_789C, 40'h12_3456_7000, 1'b0);
    t_case("r8_ratio64", 6, 16'h0500, 40'h12_3456_789C, 40'h12_3456_7000, 1'b0);
    // R2 R7: negative offset with idle gaps
    t_case("r2_neg_gap", 4, 16'hFD00, 40'h00_0FED_CBA4, 40'h7F_0000_0010, 1'b1);
    // R2: most negative offset
    t_case("r2_min", 3, 16'h8000, 40'h40_0000_0008, 40'h00_0000_0004, 1'b0);
    // R7: largest positive offset, gaps, ratio 32
    t_case("r7_gap", 5, 16'h7F00, 40'h23_4567_89A8, 40'h11_1111_1110, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule